// File: doc/BRIEF.md
# Capability Load/Store Authorization Checker

This block decides whether a capability may authorize one data memory access. Each request carries the authorizing capability: its tag, its sealed flag, its read, write and capability-transfer permissions, its decoded bounds and its address. It also carries a signed 12-bit displacement, an access size, a load/store select and a flag that marks a capability-width transfer. The block forms the effective address and checks tag, seal, permission and bounds. It reports any fault with a fixed priority, and it computes the tag that may travel with the data.

It sits between the address-generation stage of a load/store pipeline and the memory port. The result is registered, so it appears one clock after a request strobe. A capability-width access must be aligned to the capability size in bytes. A store without capability-transfer rights still proceeds, but it writes a cleared tag. An integer store reports which tag granules it overwrites, so the memory side can zero those tags.

Top module: `cap_ls_auth`

## Requirements
- R1: The effective address equals the capability address plus the 12-bit immediate, sign-extended, taken modulo 2^XLEN. It is output as `eff_addr` and also serves as the trap value.
- R2: A request whose capability tag is clear raises a capability fault with cause 0.
- R3: A tagged but sealed capability raises a capability fault with cause 1.
- R4: A load without read permission, or a store without write permission, raises a capability fault with cause 2.
- R5: A capability whose base exceeds its top (malformed bounds) raises a capability fault with cause 3.
- R6: An access of N bytes is in bounds only if base <= ea and ea + N <= top. Both comparisons use XLEN+1 bits, and top does not wrap. Otherwise a capability fault with cause 4 is raised. N is 2^acc_size for integer accesses (acc_size 0..3 gives 1, 2, 4 or 8 bytes) and CLEN/8 for capability accesses.
- R7: When several violations hold at once, the reported cause follows this order: tag, then seal, then permission, then malformed bounds, then bounds.
- R8: A capability fault sets `exc_valid`, `exc_code` = 28 and `fault_type` = 1 (data). The type encoding is 0 = fetch, 1 = data, 2 = jump. Without an exception, `exc_code`, `fault_cause` and `fault_type` read 0.
- R9: A capability-width access whose effective address is not a multiple of CLEN/8 raises code 4 for a load or code 6 for a store, with cause 0 and type 0. A capability fault on the same request takes precedence over this.
- R10: A capability load returns `tag_out` = data_tag only when the capability holds both read and capability-transfer permission. Otherwise it returns 0. An integer load always returns `tag_out` = 0.
- R11: A capability store writes `tag_out` = data_tag only when the capability holds both write and capability-transfer permission. Otherwise it writes 0.
- R12: An integer store asserts `clr_lo` to clear the tag of the granule holding ea. It also asserts `clr_hi` when the access crosses into the next CLEN/8-byte granule.
- R13: Any exception forces `tag_out`, `clr_lo` and `clr_hi` to 0.
- R14: Results appear on the clock edge after `req_valid`, qualified by `rsp_valid`. In a cycle with no request, `rsp_valid`, `exc_valid`, `tag_out`, `clr_lo` and `clr_hi` are 0, and reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| cap_tag | input | 1 | Authorizing capability tag |
| cap_sealed | input | 1 | Authorizing capability is sealed |
| perm_rd | input | 1 | Read permission |
| perm_wr | input | 1 | Write permission |
| perm_cap | input | 1 | Capability-transfer permission |
| cap_base | input | XLEN | Decoded base |
| cap_top | input | XLEN+1 | Decoded top |
| cap_addr | input | XLEN | Capability address |
| imm | input | 12 | Signed displacement |
| acc_size | input | SZW | log2 of integer access bytes |
| is_store | input | 1 | 1 = store, 0 = load |
| is_cap | input | 1 | Capability-width transfer |
| data_tag | input | 1 | Tag of the data being moved |
| rsp_valid | output | 1 | Result valid |
| eff_addr | output | XLEN | Effective address / trap value |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 6 | Exception code |
| fault_cause | output | 3 | Capability fault cause |
| fault_type | output | 2 | Capability fault type |
| tag_out | output | 1 | Tag to write to memory or register |
| clr_lo | output | 1 | Clear tag of granule holding ea |
| clr_hi | output | 1 | Clear tag of following granule |

## Verification
Wrong state in this block can sit only in its single output register. A fault there shows at the ports one clock after the request: a wrong cause or code, a tag that leaks through, or a missing granule clear. It may also appear one clock after an idle cycle, as a response or exception that should not be there. The checks therefore sample every output exactly one edge after each strobe and once more after an idle cycle. This covers the bounds edges where a wrong carry or wrap would first appear: an access ending exactly at top, top equal to 2^XLEN, and addresses that wrap.

// File: rtl/cap_ls_pkg.sv
// Shared encodings for the capability load/store checker.
// Assumes exception codes follow the standard trap cause numbering.
package cap_ls_pkg;

    typedef enum logic [2:0] {
        FC_TAG       = 3'd0,
        FC_SEAL      = 3'd1,
        FC_PERM      = 3'd2,
        FC_MALFORMED = 3'd3,
        FC_BOUNDS    = 3'd4
    } fault_cause_e;

    typedef enum logic [1:0] {
        FK_FETCH = 2'd0,
        FK_DATA  = 2'd1,
        FK_JUMP  = 2'd2
    } fault_kind_e;

    localparam logic [5:0] EXC_NONE   = 6'd0;
    localparam logic [5:0] EXC_LD_MIS = 6'd4;
    localparam logic [5:0] EXC_ST_MIS = 6'd6;
    localparam logic [5:0] EXC_CAPF   = 6'd28;

endpackage

// File: rtl/cap_ea_calc.sv
// Effective address and access footprint.
// Computes ea = addr + sext(imm), the access byte count, the capability
// alignment violation and whether the footprint crosses a tag granule.
// Assumes GRAN_B is a power of two and 2^(2^SZW-1) <= GRAN_B.
module cap_ea_calc #(
    parameter int XLEN   = 32,
    parameter int IMMW   = 12,
    parameter int GRAN_B = 8,
    parameter int SZW    = 2,
    parameter int NBW    = $clog2(GRAN_B) + 1
) (
    input  logic [XLEN-1:0] addr,
    input  logic [IMMW-1:0] imm,
    input  logic [SZW-1:0]  size_code,
    input  logic            is_cap,
    output logic [XLEN-1:0] ea,
    output logic [NBW-1:0]  nbytes,
    output logic            misaligned,
    output logic            crosses
);
    localparam int OFFW = $clog2(GRAN_B);

    logic [XLEN-1:0] imm_sx;
    logic [OFFW-1:0] off;
    logic [NBW-1:0]  span_end;

    // Address arithmetic wraps modulo 2^XLEN.
    always_comb begin
        imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        ea     = addr + imm_sx;
    end

    // Byte count: fixed granule size for capabilities, 2^size otherwise.
    always_comb begin
        if (is_cap) nbytes = NBW'(GRAN_B);
        else        nbytes = NBW'(1) << size_code;
    end

    // Granule offset drives both the alignment and the crossing test.
    always_comb begin
        off        = ea[OFFW-1:0];
        misaligned = is_cap && (off != '0);
        span_end   = NBW'(off) + nbytes;
        crosses    = span_end > NBW'(GRAN_B);
    end
endmodule

// File: rtl/cap_bounds_chk.sv
// Non-wrapping bounds check at XLEN+1 bits.
// Flags malformed bounds (base > top) and any footprint byte outside
// [base, top). Assumes top is the decoded, unwrapped XLEN+1-bit value.
module cap_bounds_chk #(
    parameter int XLEN = 32,
    parameter int NBW  = 4
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN:0]   top,
    input  logic [XLEN-1:0] ea,
    input  logic [NBW-1:0]  nbytes,
    output logic            malformed,
    output logic            out_of_bounds
);
    logic [XLEN:0] base_w;
    logic [XLEN:0] ea_w;
    logic [XLEN:0] end_w;

    // Widen every operand so the end address cannot wrap.
    always_comb begin
        base_w        = {1'b0, base};
        ea_w          = {1'b0, ea};
        end_w         = ea_w + (XLEN+1)'(nbytes);
        malformed     = base_w > top;
        out_of_bounds = (ea_w < base_w) || (end_w > top);
    end
endmodule

// File: rtl/cap_fault_prio.sv
// Priority encoder for capability faults and the capability
// misalignment exception. Capability faults always win over misalignment.
// Assumes all violation inputs are valid for the same request.
module cap_fault_prio
    import cap_ls_pkg::*;
(
    input  logic         cap_tag,
    input  logic         cap_sealed,
    input  logic         perm_ok,
    input  logic         malformed,
    input  logic         out_of_bounds,
    input  logic         misaligned,
    input  logic         is_store,
    output logic         exc,
    output logic [5:0]   code,
    output fault_cause_e cause,
    output fault_kind_e  kind
);
    // Fixed-order selection: tag, seal, permission, malformed, bounds, alignment.
    always_comb begin
        exc   = 1'b1;
        code  = EXC_CAPF;
        cause = FC_TAG;
        kind  = FK_DATA;
        if (!cap_tag) begin
            cause = FC_TAG;
        end else if (cap_sealed) begin
            cause = FC_SEAL;
        end else if (!perm_ok) begin
            cause = FC_PERM;
        end else if (malformed) begin
            cause = FC_MALFORMED;
        end else if (out_of_bounds) begin
            cause = FC_BOUNDS;
        end else if (misaligned) begin
            kind = FK_FETCH;
            code = is_store ? EXC_ST_MIS : EXC_LD_MIS;
        end else begin
            exc  = 1'b0;
            kind = FK_FETCH;
            code = EXC_NONE;
        end
    end
endmodule

// File: rtl/cap_ls_auth.sv
// Capability load/store authorization checker (top).
// Combinational check of one request, registered one cycle after req_valid.
// Strobe-qualified outputs read 0 in idle cycles; address/code fields hold.
// Assumes CLEN is a power of two >= 16 and XLEN > IMMW.
module cap_ls_auth
    import cap_ls_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CLEN   = 64,
    parameter int IMMW   = 12,
    parameter int GRAN_B = CLEN / 8,
    parameter int SZW    = $clog2($clog2(GRAN_B) + 1),
    parameter int NBW    = $clog2(GRAN_B) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            cap_tag,
    input  logic            cap_sealed,
    input  logic            perm_rd,
    input  logic            perm_wr,
    input  logic            perm_cap,
    input  logic [XLEN-1:0] cap_base,
    input  logic [XLEN:0]   cap_top,
    input  logic [XLEN-1:0] cap_addr,
    input  logic [IMMW-1:0] imm,
    input  logic [SZW-1:0]  acc_size,
    input  logic            is_store,
    input  logic            is_cap,
    input  logic            data_tag,
    output logic            rsp_valid,
    output logic [XLEN-1:0] eff_addr,
    output logic            exc_valid,
    output logic [5:0]      exc_code,
    output logic [2:0]      fault_cause,
    output logic [1:0]      fault_type,
    output logic            tag_out,
    output logic            clr_lo,
    output logic            clr_hi
);
    logic [XLEN-1:0] ea;
    logic [NBW-1:0]  nbytes;
    logic            misaligned;
    logic            crosses;
    logic            malformed;
    logic            oob;
    logic            perm_ok;
    logic            xfer_ok;
    logic            exc;
    logic [5:0]      code;
    fault_cause_e    cause;
    fault_kind_e     kind;
    logic            tag_nxt;
    logic            clr_lo_nxt;
    logic            clr_hi_nxt;

    cap_ea_calc #(
        .XLEN(XLEN), .IMMW(IMMW), .GRAN_B(GRAN_B), .SZW(SZW), .NBW(NBW)
    ) i_ea (
        .addr(cap_addr), .imm(imm), .size_code(acc_size), .is_cap(is_cap),
        .ea(ea), .nbytes(nbytes), .misaligned(misaligned), .crosses(crosses)
    );

    cap_bounds_chk #(.XLEN(XLEN), .NBW(NBW)) i_bounds (
        .base(cap_base), .top(cap_top), .ea(ea), .nbytes(nbytes),
        .malformed(malformed), .out_of_bounds(oob)
    );

    // Data permission for the direction of the access.
    always_comb begin
        perm_ok = is_store ? perm_wr : perm_rd;
        xfer_ok = perm_cap && perm_ok;
    end

    cap_fault_prio i_prio (
        .cap_tag(cap_tag), .cap_sealed(cap_sealed), .perm_ok(perm_ok),
        .malformed(malformed), .out_of_bounds(oob), .misaligned(misaligned),
        .is_store(is_store), .exc(exc), .code(code), .cause(cause), .kind(kind)
    );

    // Tag propagation and granule-clear indications; suppressed on exception.
    always_comb begin
        tag_nxt    = !exc && is_cap && data_tag && xfer_ok;
        clr_lo_nxt = !exc && is_store && !is_cap;
        clr_hi_nxt = clr_lo_nxt && crosses;
    end

    // Output register: strobe-qualified flags every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            exc_valid <= 1'b0;
            tag_out   <= 1'b0;
            clr_lo    <= 1'b0;
            clr_hi    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            exc_valid <= req_valid && exc;
            tag_out   <= req_valid && tag_nxt;
            clr_lo    <= req_valid && clr_lo_nxt;
            clr_hi    <= req_valid && clr_hi_nxt;
        end
    end

    // Output register: address and fault fields load only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_addr    <= '0;
            exc_code    <= EXC_NONE;
            fault_cause <= '0;
            fault_type  <= '0;
        end else if (req_valid) begin
            eff_addr    <= ea;
            exc_code    <= code;
            fault_cause <= (code == EXC_CAPF) ? cause : FC_TAG;
            fault_type  <= kind;
        end
    end
endmodule

// File: rtl/cap_ls_auth_chk.sv
// Temporal checks for cap_ls_auth, bound to every instance.
module cap_ls_auth_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       cap_tag,
    input logic       cap_sealed,
    input logic       perm_rd,
    input logic       perm_cap,
    input logic       is_store,
    input logic       is_cap,
    input logic       rsp_valid,
    input logic       exc_valid,
    input logic [5:0] exc_code,
    input logic [2:0] fault_cause,
    input logic       tag_out,
    input logic       clr_lo,
    input logic       clr_hi
);
    // R2
    untagged_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !cap_tag |=> exc_valid && exc_code == 6'd28 && fault_cause == 3'd0);

    // R7
    seal_before_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cap_tag && cap_sealed |=> exc_code == 6'd28 && fault_cause == 3'd1);

    // R10
    load_tag_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !is_store && !(perm_rd && perm_cap) |=> !tag_out);

    // R9
    int_no_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !is_cap |=> exc_code != 6'd4 && exc_code != 6'd6);

    // R13
    exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !tag_out && !clr_lo && !clr_hi);

    // R12
    clr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hi |-> clr_lo);

    // R14
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !exc_valid && !tag_out && !clr_lo);
endmodule

bind cap_ls_auth cap_ls_auth_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cap_tag(cap_tag),
    .cap_sealed(cap_sealed), .perm_rd(perm_rd), .perm_cap(perm_cap),
    .is_store(is_store), .is_cap(is_cap), .rsp_valid(rsp_valid),
    .exc_valid(exc_valid), .exc_code(exc_code), .fault_cause(fault_cause),
    .tag_out(tag_out), .clr_lo(clr_lo), .clr_hi(clr_hi)
);

// File: tb/test_cap_ls_auth.sv
module test_cap_ls_auth;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 300;

    typedef struct packed {
        logic        tg, sl, rd, wr, cp;
        logic [31:0] base;
        logic [32:0] top;
        logic [31:0] addr;
        logic [11:0] imm;
        logic [1:0]  sz;
        logic        st, cw, dt;
        logic        x_exc;
        logic [5:0]  x_code;
        logic [2:0]  x_cause;
        logic        x_tag, x_lo, x_hi;
        logic [31:0] x_ea;
    } vec_t;

    localparam int NV = 21;
    // fields: tg sl rd wr cp base top addr imm sz st cw dt | exc code cause tag lo hi ea
    localparam vec_t VECS [NV] = '{
        // R1 plain integer load in bounds
        '{1,0,1,0,0, 32'h1000, 33'h2000, 32'h1000, 12'h004, 2'd2, 0,0,1, 0, 6'd0, 3'd0, 0,0,0, 32'h1004},
        // R2 R7 untagged, sealed and unpermitted: tag wins
        '{0,1,0,0,0, 32'h1000, 33'h2000, 32'h1000, 12'h000, 2'd2, 0,0,0, 1, 6'd28, 3'd0, 0,0,0, 32'h1000},
        // R3 sealed
        '{1,1,1,0,0, 32'h1000, 33'h2000, 32'h1000, 12'h000, 2'd2, 0,0,0, 1, 6'd28, 3'd1, 0,0,0, 32'h1000},
        // R4 load without read
        '{1,0,0,1,0, 32'h1000, 33'h2000, 32'h1000, 12'h000, 2'd2, 0,0,0, 1, 6'd28, 3'd2, 0,0,0, 32'h1000},
        // R4 store without write, no clears (R13)
        '{1,0,1,0,0, 32'h1000, 33'h2000, 32'h1000, 12'h000, 2'd2, 1,0,0, 1, 6'd28, 3'd2, 0,0,0, 32'h1000},
        // R5 malformed bounds beats bounds
        '{1,0,1,0,0, 32'h3000, 33'h2000, 32'h3000, 12'h000, 2'd2, 0,0,0, 1, 6'd28, 3'd3, 0,0,0, 32'h3000},
        // R6 below base via negative immediate
        '{1,0,1,0,0, 32'h1000, 33'h2000, 32'h1000, 12'hFFC, 2'd2, 0,0,0, 1, 6'd28, 3'd4, 0,0,0, 32'h0FFC},
        // R6 single byte at top-1
        '{1,0,1,0,0, 32'h1000, 33'h2000, 32'h1FFF, 12'h000, 2'd0, 0,0,0, 0, 6'd0, 3'd0, 0,0,0, 32'h1FFF},
        // R6 two bytes at top-1 cross top
        '{1,0,1,0,0, 32'h1000, 33'h2000, 32'h1FFF, 12'h000, 2'd1, 0,0,0, 1, 6'd28, 3'd4, 0,0,0, 32'h1FFF},
        // R6 top = 2^32, access ends exactly there
        '{1,0,1,0,0, 32'h0, 33'h1_0000_0000, 32'hFFFF_FFFC, 12'h000, 2'd2, 0,0,0, 0, 6'd0, 3'd0, 0,0,0, 32'hFFFF_FFFC},
        // R1 address wrap
        '{1,0,1,0,0, 32'h0, 33'h1000, 32'hFFFF_FFF0, 12'h020, 2'd2, 0,0,0, 0, 6'd0, 3'd0, 0,0,0, 32'h0000_0010},
        // R9 misaligned capability load
        '{1,0,1,0,1, 32'h0, 33'h1000, 32'h0104, 12'h000, 2'd0, 0,1,1, 1, 6'd4, 3'd0, 0,0,0, 32'h0104},
        // R9 misaligned capability store
        '{1,0,0,1,1, 32'h0, 33'h1000, 32'h0104, 12'h000, 2'd0, 1,1,1, 1, 6'd6, 3'd0, 0,0,0, 32'h0104},
        // R9 bounds fault outranks misalignment
        '{1,0,1,0,1, 32'h0, 33'h1000, 32'h0FFC, 12'h000, 2'd0, 0,1,1, 1, 6'd28, 3'd4, 0,0,0, 32'h0FFC},
        // R10 capability load keeps tag
        '{1,0,1,0,1, 32'h0, 33'h1000, 32'h0100, 12'h000, 2'd0, 0,1,1, 0, 6'd0, 3'd0, 1,0,0, 32'h0100},
        // R10 capability load without transfer permission
        '{1,0,1,0,0, 32'h0, 33'h1000, 32'h0100, 12'h000, 2'd0, 0,1,1, 0, 6'd0, 3'd0, 0,0,0, 32'h0100},
        // R11 capability store keeps tag
        '{1,0,0,1,1, 32'h0, 33'h1000, 32'h0100, 12'h000, 2'd0, 1,1,1, 0, 6'd0, 3'd0, 1,0,0, 32'h0100},
        // R11 capability store without transfer permission
        '{1,0,0,1,0, 32'h0, 33'h1000, 32'h0100, 12'h000, 2'd0, 1,1,1, 0, 6'd0, 3'd0, 0,0,0, 32'h0100},
        // R12 aligned word store clears one granule
        '{1,0,0,1,0, 32'h0, 33'h1000, 32'h0100, 12'h000, 2'd2, 1,0,1, 0, 6'd0, 3'd0, 0,1,0, 32'h0100},
        // R12 word store crossing a granule clears two
        '{1,0,0,1,0, 32'h0, 33'h1000, 32'h0106, 12'h000, 2'd2, 1,0,1, 0, 6'd0, 3'd0, 0,1,1, 32'h0106},
        // R12 aligned doubleword store stays in one granule
        '{1,0,0,1,0, 32'h0, 33'h1000, 32'h0108, 12'h000, 2'd3, 1,0,1, 0, 6'd0, 3'd0, 0,1,0, 32'h0108}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        cap_tag = 1'b0, cap_sealed = 1'b0, perm_rd = 1'b0, perm_wr = 1'b0, perm_cap = 1'b0;
    logic [31:0] cap_base = '0, cap_addr = '0;
    logic [32:0] cap_top = '0;
    logic [11:0] imm = '0;
    logic [1:0]  acc_size = '0;
    logic        is_store = 1'b0, is_cap = 1'b0, data_tag = 1'b0;
    logic        rsp_valid, exc_valid, tag_out, clr_lo, clr_hi;
    logic [31:0] eff_addr;
    logic [5:0]  exc_code;
    logic [2:0]  fault_cause;
    logic [1:0]  fault_type;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_ls_auth i_cap_ls_auth (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cap_tag(cap_tag),
        .cap_sealed(cap_sealed), .perm_rd(perm_rd), .perm_wr(perm_wr),
        .perm_cap(perm_cap), .cap_base(cap_base), .cap_top(cap_top),
        .cap_addr(cap_addr), .imm(imm), .acc_size(acc_size), .is_store(is_store),
        .is_cap(is_cap), .data_tag(data_tag), .rsp_valid(rsp_valid),
        .eff_addr(eff_addr), .exc_valid(exc_valid), .exc_code(exc_code),
        .fault_cause(fault_cause), .fault_type(fault_type), .tag_out(tag_out),
        .clr_lo(clr_lo), .clr_hi(clr_hi)
    );

    task automatic check(input string req, input string what, input int idx,
                         input logic [32:0] act, input logic [32:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s case %0d: actual %h expected %h", req, what, idx, act, exp);
        end
    endtask

    // Expected results computed from the requirements.
    function automatic vec_t model(input vec_t v);
        vec_t        r = v;
        logic [31:0] ea = v.addr + {{20{v.imm[11]}}, v.imm};
        int          nb = v.cw ? 8 : (1 << v.sz);
        logic [32:0] e  = {1'b0, ea} + 33'(nb);
        logic        malf = {1'b0, v.base} > v.top;
        logic        oob  = ({1'b0, v.base} > {1'b0, ea}) || (e > v.top);
        logic        pok  = v.st ? v.wr : v.rd;
        logic        capf = !v.tg || v.sl || !pok || malf || oob;
        logic        mis  = v.cw && (ea[2:0] != 3'd0);
        r.x_ea    = ea;
        r.x_exc   = capf || mis;
        r.x_code  = capf ? 6'd28 : (mis ? (v.st ? 6'd6 : 6'd4) : 6'd0);
        r.x_cause = !capf ? 3'd0 : !v.tg ? 3'd0 : v.sl ? 3'd1 : !pok ? 3'd2 : malf ? 3'd3 : 3'd4;
        r.x_tag   = !r.x_exc && v.cw && v.dt && v.cp && pok;
        r.x_lo    = !r.x_exc && v.st && !v.cw;
        r.x_hi    = r.x_lo && ((int'(ea[2:0]) + nb) > 8);
        return r;
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        req_valid = 1'b1;
        cap_tag = v.tg; cap_sealed = v.sl; perm_rd = v.rd; perm_wr = v.wr; perm_cap = v.cp;
        cap_base = v.base; cap_top = v.top; cap_addr = v.addr; imm = v.imm;
        acc_size = v.sz; is_store = v.st; is_cap = v.cw; data_tag = v.dt;
        @(negedge clk);
        req_valid = 1'b0;
        check("R14", "rsp_valid", idx, 33'(rsp_valid), 33'd1);
        check("R1",  "eff_addr",  idx, 33'(eff_addr), 33'(v.x_ea));
        check("R8/R9", "exc_valid", idx, 33'(exc_valid), 33'(v.x_exc));
        check("R8/R9", "exc_code",  idx, 33'(exc_code), 33'(v.x_code));
        check("R7",  "fault_cause", idx, 33'(fault_cause), 33'(v.x_cause));
        check("R8",  "fault_type",  idx, 33'(fault_type), (v.x_code == 6'd28) ? 33'd1 : 33'd0);
        check("R10/R11", "tag_out", idx, 33'(tag_out), 33'(v.x_tag));
        check("R12", "clr_lo", idx, 33'(clr_lo), 33'(v.x_lo));
        check("R12", "clr_hi", idx, 33'(clr_hi), 33'(v.x_hi));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14 reset state
        check("R14", "reset rsp_valid", -1, 33'(rsp_valid), 33'd0);
        check("R14", "reset exc_valid", -1, 33'(exc_valid), 33'd0);
        check("R14", "reset exc_code",  -1, 33'(exc_code), 33'd0);
        check("R14", "reset eff_addr",  -1, 33'(eff_addr), 33'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R14 idle cycle after a request: strobed outputs return to 0
        run_vec(VECS[1], 100);
        @(negedge clk);
        check("R14", "idle rsp_valid", 101, 33'(rsp_valid), 33'd0);
        check("R14", "idle exc_valid", 101, 33'(exc_valid), 33'd0);
        run_vec(VECS[19], 102);
        @(negedge clk);
        check("R14", "idle clr_lo", 103, 33'(clr_lo), 33'd0);

        // R14 synchronous reset clears a pending fault
        run_vec(VECS[2], 104);
        rst_n = 1'b0;
        @(negedge clk);
        check("R14", "reset exc_valid", 105, 33'(exc_valid), 33'd0);
        check("R14", "reset fault_cause", 105, 33'(fault_cause), 33'd0);
        rst_n = 1'b1;

        // Random cases against the requirement model (R1..R13)
        for (int k = 0; k < NRAND; k++) begin
            vec_t v;
            logic [31:0] len;
            v = '0;
            v.tg   = ($urandom % 10) != 0;
            v.sl   = ($urandom % 8) == 0;
            v.rd   = $urandom; v.wr = $urandom; v.cp = $urandom;
            v.base = (k % 7 == 0) ? 32'hFFFF_FF00 : $urandom;
            len    = $urandom % 32'h400;
            v.top  = {1'b0, v.base} + {1'b0, len};
            if (k % 13 == 0) v.top = {1'b0, v.base} - 33'd16;
            v.addr = v.base + ($urandom % 32'h480) - 32'h40;
            v.imm  = $urandom;
            v.sz   = $urandom;
            v.st   = $urandom; v.cw = ($urandom % 3) == 0; v.dt = $urandom;
            run_vec(model(v), 1000 + k);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule